// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives one asynchronous serial channel. It runs on the system clock and uses a one-cycle `tick` strobe that arrives sixteen times per bit period. A falling edge on the synchronised line starts a frame. The start bit is confirmed low at its midpoint. Each following bit is then sampled at its own midpoint. A frame carries 8 data bits, an optional parity bit, and one or two stop bits. The finished character is stored in a holding register, together with parity, framing and overrun status for that frame.

Control inputs are read live. They select:
- receive enable
- parity enable and odd/even polarity
- the number of stop bits
- the bit order on the line
- inversion of the stored data bits
- whether the ready-to-send output is driven

Software, or a bus wrapper, reads the holding register with `rd_strobe`. It clears the interrupt flag with either `irq_ack` or `irq_clr_wr`.

Top module: `serial_rx_channel`

## Requirements
- R1: While `rx_en` is 0, no frame is received: `rx_full` and `irq_req` never rise, and `rts_n` is 1.
- R2: A low pulse on `rxd` that has returned high by the start bit's midpoint (tick 8 after the edge) is discarded. No character is stored, and the receiver is ready for the next edge.
- R3: A frame is: start (0), 8 data bits, parity if `par_en`=1, then one stop bit (`two_stop`=0) or two (`two_stop`=1). With `msb_first`=0, the first data bit on the line lands in `rx_data[0]`.
- R4: With `msb_first`=1, the first data bit on the line lands in `rx_data[7]` and the last lands in `rx_data[0]`.
- R5: With `invert`=1, every stored data bit is the complement of the line bit. With `invert`=0, the data is stored unchanged.
- R6: When a frame completes, `rx_data` takes the character and `rx_full` becomes 1. `rx_data` changes at no other time except reset. A `rd_strobe` pulse clears `rx_full` on the next edge, unless a frame completes in that same cycle.
- R7: `irq_req` becomes 1 when a frame completes. It stays 1 until `irq_ack` or `irq_clr_wr` is pulsed. If a completion and a clear fall in the same cycle, the completion wins.
- R8: At each completion, `parity_err` is set to 1 if the XOR of the 8 line data bits and the line parity bit differs from `par_odd`. Even parity uses `par_odd`=0 and odd parity uses `par_odd`=1. The flag is 0 when `par_en`=0.
- R9: At each completion, `frame_err` is set to 1 if any sampled stop bit was 0, and to 0 otherwise.
- R10: At each completion, `overrun` is set to 1 if `rx_full` was still 1 and was not being read in that cycle. The new character replaces the old one.
- R11: When `rts_en`=1, `rts_n` is 0 while the receiver is enabled, idle and the buffer is empty. It goes to 1 once a start edge is seen, and stays 1 until the buffer has been read. When `rts_en`=0, `rts_n` is held at 1.
- R12: A synchronous `rst` returns the receiver to idle with `rx_data`=0, all flags 0 and `rts_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe, 16 per bit period |
| rx_en | input | 1 | Receive enable |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| msb_first | input | 1 | 1 = first data bit is bit 7 |
| invert | input | 1 | 1 = complement data before storage |
| rts_en | input | 1 | Drive the ready-to-send output |
| rxd | input | 1 | Serial receive line, idle high |
| rd_strobe | input | 1 | Holding register read pulse |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_clr_wr | input | 1 | Software clear of the interrupt flag |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Holding register holds an unread character |
| irq_req | output | 1 | Sticky interrupt request |
| parity_err | output | 1 | Parity mismatch in the last frame |
| frame_err | output | 1 | Low stop bit in the last frame |
| overrun | output | 1 | Last frame overwrote an unread character |
| rts_n | output | 1 | Ready to send, active low |

## Verification
A bit counter or tick phase that slips shows up on the very next completion. The symptom is a character shifted by one position, or a false `parity_err` or `frame_err`. It appears roughly one bit period later than a correct receiver would report.

A stuck state machine shows up as `rts_n` remaining 1 after the buffer is read. It can also show up as `irq_req` never rising for a frame that was sent.

A wrong bit order or inversion is visible as soon as a deliberately asymmetric character is stored. Overrun logic that looks at the wrong cycle shows up only on the second of two unread frames.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP
   } rx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2+((STAGES==1)?1:0):0] , din};
         end
         assign dout = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic rx_en,
   input  logic par_en,
   input  logic two_stop,
   input  logic rxs,
   output logic start_det,
   output logic data_stb,
   output logic par_stb,
   output logic done,
   output logic frame_bad,
   output logic idle
);
   localparam int CNT_W     = $clog2(OVERSAMPLE);
   localparam int IDX_W     = $clog2(DATA_W);
   localparam int SAMPLE_PT = OVERSAMPLE / 2;

   rx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] bit_idx;
   logic             stop_idx;
   logic             stop_bad;
   logic             rx_prev;
   logic             mid;
   logic             last_stop;

   assign mid       = tick && (cnt == CNT_W'(OVERSAMPLE-1));
   assign last_stop = !two_stop || stop_idx;
   assign start_det = (state == RX_IDLE) && rx_en && rx_prev && !rxs;
   assign data_stb  = (state == RX_DATA) && mid;
   assign par_stb   = (state == RX_PARITY) && mid;
   assign done      = rx_en && (state == RX_STOP) && mid && last_stop;
   assign frame_bad = stop_bad || !rxs;
   assign idle      = (state == RX_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         stop_idx <= 1'b0;
         stop_bad <= 1'b0;
         rx_prev  <= 1'b1;
      end else begin
         rx_prev <= rxs;
         if (!rx_en) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: if (start_det) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
               RX_START: if (tick) begin
                  if (cnt == CNT_W'(SAMPLE_PT-1)) begin
                     cnt     <= '0;
                     bit_idx <= '0;
                     state   <= rxs ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: if (tick) begin
                  if (mid) begin
                     cnt <= '0;
                     if (bit_idx == IDX_W'(DATA_W-1)) begin
                        state    <= par_en ? RX_PARITY : RX_STOP;
                        stop_idx <= 1'b0;
                        stop_bad <= 1'b0;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PARITY: if (tick) begin
                  if (mid) begin
                     cnt   <= '0;
                     state <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: if (tick) begin
                  if (mid) begin
                     cnt      <= '0;
                     stop_bad <= stop_bad || !rxs;
                     if (last_stop) state <= RX_IDLE;
                     else           stop_idx <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_det,
   input  logic              data_stb,
   input  logic              par_stb,
   input  logic              bit_in,
   input  logic              msb_first,
   input  logic              invert,
   input  logic              par_odd,
   output logic [DATA_W-1:0] word,
   output logic              par_bad
);
   logic [DATA_W-1:0] sh;
   logic              acc;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh      <= '0;
         acc     <= 1'b0;
         par_bad <= 1'b0;
      end else if (start_det) begin
         acc     <= 1'b0;
         par_bad <= 1'b0;
      end else if (data_stb) begin
         acc <= acc ^ bit_in;
         if (msb_first) sh <= {sh[DATA_W-2:0], bit_in};
         else           sh <= {bit_in, sh[DATA_W-1:1]};
      end else if (par_stb) begin
         par_bad <= acc ^ bit_in ^ par_odd;
      end
   end

   assign word = sh ^ {DATA_W{invert}};
endmodule

// File: rtl/srx_holding.sv
module srx_holding #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              rts_en,
   input  logic              idle,
   input  logic              start_det,
   input  logic              done,
   input  logic [DATA_W-1:0] word,
   input  logic              par_bad,
   input  logic              frame_bad,
   input  logic              rd_strobe,
   input  logic              irq_ack,
   input  logic              irq_clr_wr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              irq_req,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun,
   output logic              rts_n
);
   logic rts_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_data    <= '0;
         rx_full    <= 1'b0;
         irq_req    <= 1'b0;
         parity_err <= 1'b0;
         frame_err  <= 1'b0;
         overrun    <= 1'b0;
         rts_q      <= 1'b1;
      end else begin
         if (done) begin
            rx_data    <= word;
            rx_full    <= 1'b1;
            parity_err <= par_bad;
            frame_err  <= frame_bad;
            overrun    <= rx_full && !rd_strobe;
         end else if (rd_strobe) begin
            rx_full <= 1'b0;
         end

         if (done)                         irq_req <= 1'b1;
         else if (irq_ack || irq_clr_wr)   irq_req <= 1'b0;

         if (start_det || !rx_en)          rts_q <= 1'b1;
         else if (idle && !rx_full)        rts_q <= 1'b0;
      end
   end

   assign rts_n = rts_en ? rts_q : 1'b1;
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel #(
   parameter int DATA_W      = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              rx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              msb_first,
   input  logic              invert,
   input  logic              rts_en,
   input  logic              rxd,
   input  logic              rd_strobe,
   input  logic              irq_ack,
   input  logic              irq_clr_wr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              irq_req,
   output logic              parity_err,
   output logic              frame_err,
   output logic              overrun,
   output logic              rts_n
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              rxs;
   logic              start_det;
   logic              data_stb;
   logic              par_stb;
   logic              frame_done;
   logic              frame_bad;
   logic              idle;
   logic [DATA_W-1:0] word;
   logic              par_bad;

   srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(rxd), .dout(rxs)
   );

   srx_frame_fsm #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
      .clk(clk), .rst(rst), .tick(tick), .rx_en(rx_en), .par_en(par_en),
      .two_stop(two_stop), .rxs(rxs), .start_det(start_det),
      .data_stb(data_stb), .par_stb(par_stb), .done(frame_done),
      .frame_bad(frame_bad), .idle(idle)
   );

   srx_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst(rst), .start_det(start_det), .data_stb(data_stb),
      .par_stb(par_stb), .bit_in(rxs), .msb_first(msb_first),
      .invert(invert), .par_odd(par_odd), .word(word), .par_bad(par_bad)
   );

   srx_holding #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst(rst), .rx_en(rx_en), .rts_en(rts_en), .idle(idle),
      .start_det(start_det), .done(frame_done), .word(word),
      .par_bad(par_bad), .frame_bad(frame_bad), .rd_strobe(rd_strobe),
      .irq_ack(irq_ack), .irq_clr_wr(irq_clr_wr), .rx_data(rx_data),
      .rx_full(rx_full), .irq_req(irq_req), .parity_err(parity_err),
      .frame_err(frame_err), .overrun(overrun), .rts_n(rts_n)
   );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_en,
   input logic              rd_strobe,
   input logic              irq_ack,
   input logic              irq_clr_wr,
   input logic              frame_done,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_full,
   input logic              irq_req,
   input logic              rts_n
);
   AST_RX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_full) |-> $past(rx_en));                              // R1
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
      !frame_done |=> $stable(rx_data));                             // R6
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
      (rd_strobe && !frame_done) |=> !rx_full);                      // R6
   AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_full) |-> irq_req);                                   // R7
   AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      ((irq_ack || irq_clr_wr) && !frame_done) |=> !irq_req);        // R7
   AST_RTS_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
      rx_full |-> rts_n);                                            // R11
   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (!rx_full && !irq_req && rts_n && rx_data == '0));     // R12
endmodule

bind serial_rx_channel srx_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .rx_en(rx_en), .rd_strobe(rd_strobe),
   .irq_ack(irq_ack), .irq_clr_wr(irq_clr_wr), .frame_done(frame_done),
   .rx_data(rx_data), .rx_full(rx_full), .irq_req(irq_req), .rts_n(rts_n)
);

// File: tb/serial_rx_channel_tb.sv
module serial_rx_channel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int BIT_CLKS   = 16 * TICK_DIV;

   typedef struct packed {
      logic [7:0] d;
      logic       pe;
      logic       fe;
      logic       ov;
   } exp_t;

   logic clk = 0, rst = 1, tick = 0;
   logic rx_en = 1, par_en = 0, par_odd = 0, two_stop = 0;
   logic msb_first = 0, invert = 0, rts_en = 1, rxd = 1;
   logic rd_strobe = 0, irq_ack = 0, irq_clr_wr = 0;
   logic [7:0] rx_data;
   logic rx_full, irq_req, parity_err, frame_err, overrun, rts_n;

   int total = 0, bad = 0, tdiv = 0;
   bit mon_en = 1, hold_reads = 0, finished = 0;
   exp_t q[$];

   serial_rx_channel u_dut (
      .clk(clk), .rst(rst), .tick(tick), .rx_en(rx_en), .par_en(par_en),
      .par_odd(par_odd), .two_stop(two_stop), .msb_first(msb_first),
      .invert(invert), .rts_en(rts_en), .rxd(rxd), .rd_strobe(rd_strobe),
      .irq_ack(irq_ack), .irq_clr_wr(irq_clr_wr), .rx_data(rx_data),
      .rx_full(rx_full), .irq_req(irq_req), .parity_err(parity_err),
      .frame_err(frame_err), .overrun(overrun), .rts_n(rts_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
      tick <= (tdiv == TICK_DIV-1);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic line_bit(input logic v);
      rxd = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   // raw: line data byte, sent bit0 first or bit7 first per msb_first
   task automatic send_frame(input logic [7:0] raw, input bit bad_par,
                             input int bad_stop, input bit expect_it,
                             input bit exp_ov, input bit rts_chk);
      logic pbit;
      exp_t e;
      pbit = (^raw) ^ par_odd ^ bad_par;
      if (expect_it) begin
         e.d  = invert ? ~raw : raw;
         e.pe = par_en && bad_par;
         e.fe = (bad_stop != 0);
         e.ov = exp_ov;
         q.push_back(e);
      end
      line_bit(1'b0);
      if (rts_chk) check(rts_n == 1'b1, "R11 rts busy during frame", rts_n, 1);
      for (int k = 0; k < 8; k++) line_bit(msb_first ? raw[7-k] : raw[k]);
      if (par_en) line_bit(pbit);
      line_bit(bad_stop == 1 ? 1'b0 : 1'b1);
      if (two_stop) line_bit(bad_stop == 2 ? 1'b0 : 1'b1);
      line_bit(1'b1);
      line_bit(1'b1);
   endtask

   // monitor: scoreboard pop and compare on each interrupt
   initial begin
      forever begin
         @(negedge clk);
         if (mon_en && irq_req) begin
            if (q.size() == 0) begin
               check(0, "R7 unexpected completion", rx_data, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(rx_data == e.d && parity_err == e.pe &&
                     frame_err == e.fe && overrun == e.ov && rx_full,
                     "R3 R4 R5 R6 R8 R9 R10 frame result",
                     {rx_data, parity_err, frame_err, overrun},
                     {e.d, e.pe, e.fe, e.ov});
            end
            irq_ack   = 1'b1;
            rd_strobe = !hold_reads;
            @(negedge clk);
            irq_ack   = 1'b0;
            rd_strobe = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         check(0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R12 reset state
      check(rx_full == 0 && irq_req == 0 && rx_data == 0 && rts_n == 1 &&
            parity_err == 0 && frame_err == 0 && overrun == 0,
            "R12 reset state", {rx_data, rx_full, irq_req, rts_n}, 8'h0 << 3 | 1);
      rst = 0;
      repeat (4) @(negedge clk);
      check(rts_n == 0, "R11 ready when idle and empty", rts_n, 0);

      // R3 LSB first, no parity, one stop
      send_frame(8'hA5, 0, 0, 1, 0, 1);
      send_frame(8'h31, 0, 0, 1, 0, 0);
      check(rx_full == 0, "R6 read clears full", rx_full, 0);
      check(rts_n == 0, "R11 ready after read", rts_n, 0);
      // R4 MSB first
      msb_first = 1;
      send_frame(8'h1E, 0, 0, 1, 0, 0);
      send_frame(8'hC4, 0, 0, 1, 0, 0);
      msb_first = 0;
      // R5 inversion
      invert = 1;
      send_frame(8'h0F, 0, 0, 1, 0, 0);
      invert = 0;
      // R8 parity even ok, odd ok, even corrupted, odd corrupted
      par_en = 1;
      send_frame(8'h5A, 0, 0, 1, 0, 0);
      par_odd = 1;
      send_frame(8'h81, 0, 0, 1, 0, 0);
      send_frame(8'h07, 1, 0, 1, 0, 0);
      par_odd = 0;
      send_frame(8'h33, 1, 0, 1, 0, 0);
      par_en = 0;
      // R3 two stop bits; R9 bad second and bad single stop
      two_stop = 1;
      send_frame(8'h6C, 0, 0, 1, 0, 0);
      send_frame(8'h92, 0, 2, 1, 0, 0);
      two_stop = 0;
      send_frame(8'hFE, 0, 1, 1, 0, 0);

      // R10 overrun: two unread frames
      hold_reads = 1;
      send_frame(8'h11, 0, 0, 1, 0, 0);
      send_frame(8'h22, 0, 0, 1, 1, 0);
      check(rx_full == 1 && rts_n == 1, "R11 busy while full", {rx_full, rts_n}, 3);
      rd_strobe = 1; @(negedge clk); rd_strobe = 0;
      @(negedge clk);
      check(rx_full == 0, "R6 full cleared by read", rx_full, 0);
      hold_reads = 0;

      // R7 software clear, monitor off
      mon_en = 0;
      send_frame(8'h4B, 0, 0, 0, 0, 0);
      check(irq_req == 1 && rx_full == 1 && rx_data == 8'h4B,
            "R7 irq set on completion", {rx_data, irq_req}, {8'h4B, 1'b1});
      irq_clr_wr = 1; @(negedge clk); irq_clr_wr = 0;
      check(irq_req == 0 && rx_full == 1, "R7 software clear", {irq_req, rx_full}, 1);
      rd_strobe = 1; @(negedge clk); rd_strobe = 0;
      @(negedge clk);

      // R2 glitch shorter than half a bit
      rxd = 0; repeat (2 * TICK_DIV) @(negedge clk); rxd = 1;
      repeat (20 * TICK_DIV) @(negedge clk);
      check(irq_req == 0 && rx_full == 0 && rts_n == 0, "R2 glitch ignored",
            {irq_req, rx_full, rts_n}, 0);

      // R1 receive disabled
      rx_en = 0;
      repeat (3) @(negedge clk);
      check(rts_n == 1, "R1 rts high when disabled", rts_n, 1);
      send_frame(8'h77, 0, 0, 0, 0, 0);
      check(irq_req == 0 && rx_full == 0, "R1 no reception when disabled",
            {irq_req, rx_full}, 0);
      rx_en = 1;
      repeat (3) @(negedge clk);

      // R11 flow control disabled
      rts_en = 0;
      repeat (2) @(negedge clk);
      check(rts_n == 1, "R11 rts held high when flow control off", rts_n, 1);
      rts_en = 1;
      mon_en = 1;
      send_frame(8'h3A, 0, 0, 1, 0, 0);
      repeat (10) @(negedge clk);
      check(q.size() == 0, "R6 all expected frames received", q.size(), 0);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule